// File: doc/BRIEF.md
# Register-Mapped Transmit Packet FIFO

This block accepts 32-bit words from a processor through single-cycle register writes and holds them in a transmit buffer. Nothing leaves the buffer until software writes the packet size in bytes to a length register. The block then checks that size against the number of words pushed since the previous commit. A correct size releases those words as one AXI4-Stream packet, with tlast on the final word. A wrong size discards them and raises an error flag.

An interrupt status register records four transmit events: flush done, length mismatch, packet sent and push overrun. A matching enable register selects which events drive the level interrupt output. Writes to the status register clear bits in write-one-to-clear fashion. Two keyed registers reset the block. The first flushes only the buffer. The second returns the whole block to its reset state.

Top module: `txfifo_top`

## Requirements
- R1: After reset, the vacancy register (offset 0x0C) reads DEPTH-4. The status register (0x00) and the enable register (0x04) read 0, txValid is low and irqOut is low. Reads of unmapped offsets return 0.
- R2: Each write to offset 0x10 stores one word and lowers the vacancy reading by one. Uncommitted words never make txValid high.
- R3: Writing a byte count to offset 0x14 that equals 4 times the number of pending words commits those words. They go out on the stream in push order, with txLast high on the final word only.
- R4: Words pushed after a commit stay held until the next length write. Several committed packets queue and go out one after another, each framed by its own txLast.
- R5: While txValid is high and txReady is low, txValid, txData and txLast stay unchanged.
- R6: Status bit 27 is set in the cycle after the final word of a packet is accepted on the stream.
- R7: A committed length that is zero, not a multiple of 4, or not 4 times the pending word count sets status bit 25. It also discards the pending words, so vacancy is restored for them. Packets committed earlier are unaffected.
- R8: A push while vacancy reads 0 sets status bit 28, and the word is dropped.
- R9: Writing 0xA5 to offset 0x08 empties the buffer (vacancy back to DEPTH-4, txValid low) and sets status bit 24. Any other value written there has no effect.
- R10: Writing 0xA5 to offset 0x28 clears the buffer, the status register and the enable register. Any other value written there has no effect.
- R11: A write to the status register clears exactly the bits that are 1 in the written value and leaves the others unchanged.
- R12: irqOut is high when any status bit is set whose enable bit is also set, and it stays high until that status bit is cleared. The enable register holds only bits 24, 25, 27 and 28, so writing all ones reads back 0x1B000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte offset of the register being accessed |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| txData | output | 32 | Stream data |
| txValid | output | 1 | Stream valid |
| txReady | input | 1 | Stream ready from the sink |
| txLast | output | 1 | Marks the final word of a packet |
| irqOut | output | 1 | Level interrupt |

## Verification
The embedded properties check the following on every cycle:
- Buffer occupancy never exceeds DEPTH-4, and the pending count never exceeds the occupancy.
- Stream outputs hold steady under backpressure.
- The sent, overrun and mismatch bits rise only after their own cause.
- A keyed core reset clears status and enable.

Only the bench scenarios can show the following:
- Words come out in push order, and packets are framed correctly across queued commits.
- A bad length discards the right words while an earlier packet survives.
- The 13th push into a full buffer is really lost.
- Non-key values at the two reset offsets leave all state alone.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

  // Register byte offsets; software decodes these, so they are fixed.
  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_ENABLE   = 8'h04;
  localparam logic [7:0] OFS_FLUSH    = 8'h08;
  localparam logic [7:0] OFS_VACANCY  = 8'h0C;
  localparam logic [7:0] OFS_PUSH     = 8'h10;
  localparam logic [7:0] OFS_COMMIT   = 8'h14;
  localparam logic [7:0] OFS_CORE_RST = 8'h28;

  localparam logic [31:0] RESET_KEY = 32'h0000_00A5;

  // Status bit positions.
  localparam int BIT_FLUSHED  = 24;
  localparam int BIT_MISMATCH = 25;
  localparam int BIT_SENT     = 27;
  localparam int BIT_OVERRUN  = 28;

  localparam logic [31:0] STAT_MASK = 32'h1B00_0000;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic push;     // store regWrData at the write pointer
    logic commit;   // close the pending words as one packet
    logic discard;  // drop the pending words
    logic flush;    // empty the whole buffer
  } ctrlStrobes_t;

endpackage

// File: rtl/txfifo_datapath.sv
module txfifo_datapath
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] pushWord,
  output logic [CNT_W-1:0]  usedWords,
  output logic [CNT_W-1:0]  pendingWords,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  output logic              packetDone
);

  localparam int PTR_W = CNT_W - 1;
  localparam int CAP = DEPTH - 4;

  logic [CNT_W-1:0]  wrPtr, commitPtr, rdPtr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  lastMark;
  logic [PTR_W-1:0]  wrIdx, rdIdx, prevIdx;
  logic              popNow;

  assign wrIdx   = wrPtr[PTR_W-1:0];
  assign rdIdx   = rdPtr[PTR_W-1:0];
  assign prevIdx = wrIdx - PTR_W'(1);

  assign txValid    = (rdPtr != commitPtr);
  assign txData     = mem[rdIdx];
  assign txLast     = lastMark[rdIdx];
  assign popNow     = txValid && txReady;
  assign packetDone = popNow && txLast;

  assign usedWords    = wrPtr - rdPtr;
  assign pendingWords = wrPtr - commitPtr;

  // Storage carries no reset; only pointers and marks do.
  always_ff @(posedge clk) begin
    if (strb.push) mem[wrIdx] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
      lastMark  <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
      lastMark  <= '0;
    end else begin
      if (strb.push) begin
        wrPtr           <= wrPtr + CNT_W'(1);
        lastMark[wrIdx] <= 1'b0;
      end
      if (strb.commit) begin
        commitPtr         <= wrPtr;
        lastMark[prevIdx] <= 1'b1;
      end
      if (strb.discard) wrPtr <= commitPtr;
      if (popNow) rdPtr <= rdPtr + CNT_W'(1);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedWords <= CNT_W'(CAP));

  // R4
  pending_within_used_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingWords <= usedWords);

  // R5
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.flush) |=>
      (txValid && $stable(txData) && $stable(txLast)));

endmodule

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [CNT_W-1:0] usedWords,
  input  logic [CNT_W-1:0] pendingWords,
  input  logic             packetDone,
  output ctrlStrobes_t     strb,
  output logic             irqOut
);

  localparam int CAP = DEPTH - 4;

  logic [31:0] statusReg, enableReg;
  logic [31:0] setVec, clrVec;
  logic wrStatus, wrEnable, wrFlush, wrPush, wrCommit, wrCore;
  logic keyHit, bufFull, lenOk, coreKey, flushKey;

  assign wrStatus = regWrEn && (regAddr == OFS_STATUS);
  assign wrEnable = regWrEn && (regAddr == OFS_ENABLE);
  assign wrFlush  = regWrEn && (regAddr == OFS_FLUSH);
  assign wrPush   = regWrEn && (regAddr == OFS_PUSH);
  assign wrCommit = regWrEn && (regAddr == OFS_COMMIT);
  assign wrCore   = regWrEn && (regAddr == OFS_CORE_RST);

  assign keyHit   = (regWrData == RESET_KEY);
  assign flushKey = wrFlush && keyHit;
  assign coreKey  = wrCore && keyHit;
  assign bufFull  = (usedWords >= CNT_W'(CAP));

  // Length is accepted only as a nonzero whole-word count equal to pending.
  assign lenOk = (regWrData[1:0] == 2'b00) && (regWrData != 32'd0) &&
                 (regWrData[31:2] == 30'(pendingWords));

  assign strb.push    = wrPush && !bufFull;
  assign strb.commit  = wrCommit && lenOk;
  assign strb.discard = wrCommit && !lenOk;
  assign strb.flush   = flushKey || coreKey;

  always_comb begin
    setVec = '0;
    if (flushKey)            setVec[BIT_FLUSHED]  = 1'b1;
    if (wrCommit && !lenOk)  setVec[BIT_MISMATCH] = 1'b1;
    if (packetDone)          setVec[BIT_SENT]     = 1'b1;
    if (wrPush && bufFull)   setVec[BIT_OVERRUN]  = 1'b1;
  end

  assign clrVec = wrStatus ? (regWrData & STAT_MASK) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      enableReg <= '0;
    end else if (coreKey) begin
      statusReg <= '0;
      enableReg <= '0;
    end else begin
      // A new event wins over a clear landing in the same cycle.
      statusReg <= (statusReg & ~clrVec) | setVec;
      if (wrEnable) enableReg <= regWrData & STAT_MASK;
    end
  end

  assign irqOut = |(statusReg & enableReg);

  always_comb begin
    case (regAddr)
      OFS_STATUS:  regRdData = statusReg;
      OFS_ENABLE:  regRdData = enableReg;
      OFS_VACANCY: regRdData = 32'(CNT_W'(CAP) - usedWords);
      default:     regRdData = 32'd0;
    endcase
  end

  // R6
  sent_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[BIT_SENT]) |-> $past(packetDone));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[BIT_OVERRUN]) |-> $past(wrPush && bufFull));

  // R7
  mismatch_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[BIT_MISMATCH]) |-> $past(wrCommit));

  // R10
  core_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreKey |=> (statusReg == 32'd0 && enableReg == 32'd0));

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == 32'd0) |-> !irqOut);

endmodule

// File: rtl/txfifo_top.sv
module txfifo_top
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [31:0] txData,
  output logic        txValid,
  input  logic        txReady,
  output logic        txLast,
  output logic        irqOut
);

  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] usedWords, pendingWords;
  logic             packetDone;

  txfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .usedWords(usedWords), .pendingWords(pendingWords),
    .packetDone(packetDone), .strb(strb), .irqOut(irqOut)
  );

  txfifo_datapath #(.DEPTH(DEPTH), .DATA_W(32)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .pushWord(regWrData),
    .usedWords(usedWords), .pendingWords(pendingWords),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .txLast(txLast), .packetDone(packetDone)
  );

endmodule

// File: tb/sim_txfifo_top.sv
module sim_txfifo_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CAP = DEPTH - 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic [31:0] txData;
  logic        txValid;
  logic        txReady = 1'b0;
  logic        txLast;
  logic        irqOut;

  int vecCount = 0;
  int failCount = 0;

  logic [31:0] expWords [0:63];
  int          expN;
  logic [31:0] gotWords [0:63];
  logic        gotLast  [0:63];
  int          gotN;

  txfifo_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .txData(txData),
    .txValid(txValid), .txReady(txReady), .txLast(txLast), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expVacancy(input int used);
    return 32'(CAP - used);
  endfunction

  function automatic logic expIrq(input logic [31:0] st, input logic [31:0] en);
    return |(st & en);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = $urandom;
      expWords[expN] = w;
      expN++;
      wrReg(8'h10, w);
    end
  endtask

  task automatic collect(input bit rndReady);
    gotN = 0;
    for (int g = 0; g < 400; g++) begin
      txReady = rndReady ? 1'($urandom_range(1, 0)) : 1'b1;
      #1;
      if (txValid && txReady) begin
        gotWords[gotN] = txData;
        gotLast[gotN] = txLast;
        gotN++;
        if (txLast) begin
          @(negedge clk);
          break;
        end
      end
      @(negedge clk);
    end
    txReady = 1'b0;
  endtask

  task automatic checkPacket(input string req, input int base, input int n);
    chk(req, 32'(gotN), 32'(n));
    for (int i = 0; i < n && i < gotN; i++) begin
      chk(req, gotWords[i], expWords[base + i]);
      chk(req, 32'(gotLast[i]), 32'(i == n - 1));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] rv, d0;
    logic l0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(8'h0C, rv); chk("R1 vacancy", rv, expVacancy(0));
    rdReg(8'h00, rv); chk("R1 status", rv, 32'd0);
    rdReg(8'h04, rv); chk("R1 enable", rv, 32'd0);
    rdReg(8'h20, rv); chk("R1 unmapped", rv, 32'd0);
    chk("R1 valid", 32'(txValid), 32'd0);
    chk("R1 irq", 32'(irqOut), 32'd0);

    // R2 pushes lower vacancy, nothing streams before commit
    expN = 0;
    pushWords(3);
    rdReg(8'h0C, rv); chk("R2 vacancy", rv, expVacancy(3));
    repeat (2) @(negedge clk);
    chk("R2 no valid", 32'(txValid), 32'd0);

    // R3 commit and stream
    wrReg(8'h14, 32'd12);
    collect(1'b0);
    checkPacket("R3", 0, 3);
    rdReg(8'h0C, rv); chk("R3 vacancy after send", rv, expVacancy(0));

    // R6 sent bit; R11 selective clear
    rdReg(8'h00, rv); chk("R6 sent bit", rv, 32'h0800_0000);
    wrReg(8'h00, 32'h0200_0000);
    rdReg(8'h00, rv); chk("R11 other bit kept", rv, 32'h0800_0000);
    wrReg(8'h00, 32'h0800_0000);
    rdReg(8'h00, rv); chk("R11 bit cleared", rv, 32'd0);

    // R3 random packets with random backpressure
    for (int it = 0; it < 16; it++) begin
      int n;
      n = $urandom_range(CAP, 1);
      expN = 0;
      pushWords(n);
      rdReg(8'h0C, rv); chk("R2 random vacancy", rv, expVacancy(n));
      wrReg(8'h14, 32'(4 * n));
      collect(1'b1);
      checkPacket("R3 random", 0, n);
      rdReg(8'h00, rv); chk("R6 random sent", rv, 32'h0800_0000);
      wrReg(8'h00, 32'h0800_0000);
    end

    // R4 queued packets and held tail
    expN = 0;
    pushWords(2); wrReg(8'h14, 32'd8);
    pushWords(3); wrReg(8'h14, 32'd12);
    pushWords(1);
    collect(1'b0); checkPacket("R4 first", 0, 2);
    collect(1'b0); checkPacket("R4 second", 2, 3);
    txReady = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 held tail not valid", 32'(txValid), 32'd0);
    txReady = 1'b0;
    rdReg(8'h0C, rv); chk("R4 held vacancy", rv, expVacancy(1));
    wrReg(8'h14, 32'd4);
    collect(1'b0); checkPacket("R4 tail", 5, 1);
    wrReg(8'h00, 32'hFFFF_FFFF);

    // R5 backpressure holds outputs
    expN = 0;
    pushWords(3); wrReg(8'h14, 32'd12);
    d0 = txData; l0 = txLast;
    repeat (4) @(negedge clk);
    chk("R5 valid held", 32'(txValid), 32'd1);
    chk("R5 data held", txData, d0);
    chk("R5 data is first", txData, expWords[0]);
    chk("R5 last held", 32'(txLast), 32'(l0));
    collect(1'b0); checkPacket("R5", 0, 3);
    wrReg(8'h00, 32'hFFFF_FFFF);

    // R7 mismatch: wrong count, earlier packet survives
    expN = 0;
    pushWords(2); wrReg(8'h14, 32'd8);
    pushWords(3); wrReg(8'h14, 32'd4);
    expN = 2;
    rdReg(8'h00, rv); chk("R7 mismatch bit", rv, 32'h0200_0000);
    rdReg(8'h0C, rv); chk("R7 discarded vacancy", rv, expVacancy(2));
    collect(1'b0); checkPacket("R7 survivor", 0, 2);
    wrReg(8'h00, 32'hFFFF_FFFF);
    // R7 non-multiple of 4
    pushWords(2); wrReg(8'h14, 32'd6);
    rdReg(8'h00, rv); chk("R7 odd length", rv, 32'h0200_0000);
    rdReg(8'h0C, rv); chk("R7 odd vacancy", rv, expVacancy(0));
    chk("R7 odd no valid", 32'(txValid), 32'd0);
    wrReg(8'h00, 32'hFFFF_FFFF);
    // R7 zero length
    pushWords(1); wrReg(8'h14, 32'd0);
    rdReg(8'h00, rv); chk("R7 zero length", rv, 32'h0200_0000);
    rdReg(8'h0C, rv); chk("R7 zero vacancy", rv, expVacancy(0));
    wrReg(8'h00, 32'hFFFF_FFFF);

    // R8 overrun: 13th push into a 12-slot buffer
    expN = 0;
    pushWords(CAP);
    wrReg(8'h10, 32'hDEAD_BEEF);
    rdReg(8'h00, rv); chk("R8 overrun bit", rv, 32'h1000_0000);
    rdReg(8'h0C, rv); chk("R8 vacancy zero", rv, 32'd0);
    wrReg(8'h14, 32'(4 * CAP));
    collect(1'b0); checkPacket("R8 dropped word", 0, CAP);
    wrReg(8'h00, 32'hFFFF_FFFF);

    // R9 flush, non-key ignored
    expN = 0;
    pushWords(3); wrReg(8'h14, 32'd12); pushWords(1);
    wrReg(8'h08, 32'h0000_005A);
    rdReg(8'h0C, rv); chk("R9 non-key ignored", rv, expVacancy(4));
    chk("R9 non-key valid", 32'(txValid), 32'd1);
    wrReg(8'h08, 32'h0000_00A5);
    rdReg(8'h0C, rv); chk("R9 flushed vacancy", rv, expVacancy(0));
    chk("R9 flushed valid", 32'(txValid), 32'd0);
    rdReg(8'h00, rv); chk("R9 flush bit", rv, 32'h0100_0000);

    // R12 interrupt gating
    wrReg(8'h04, 32'hFFFF_FFFF);
    rdReg(8'h04, rv); chk("R12 enable readback", rv, 32'h1B00_0000);
    chk("R12 irq high", 32'(irqOut), 32'(expIrq(32'h0100_0000, 32'h1B00_0000)));
    wrReg(8'h00, 32'h0100_0000);
    chk("R12 irq cleared", 32'(irqOut), 32'd0);
    wrReg(8'h04, 32'h0800_0000);
    expN = 0;
    pushWords(1); wrReg(8'h14, 32'd0);
    chk("R12 masked mismatch", 32'(irqOut), 32'd0);
    pushWords(1); expN = 1; expWords[0] = expWords[1];
    wrReg(8'h14, 32'd4);
    collect(1'b0); checkPacket("R12 packet", 0, 1);
    repeat (3) @(negedge clk);
    chk("R12 irq level held", 32'(irqOut), 32'd1);
    // R11 clear one of two set bits
    rdReg(8'h00, rv); chk("R11 two bits", rv, 32'h0A00_0000);
    wrReg(8'h00, 32'h0200_0000);
    rdReg(8'h00, rv); chk("R11 one left", rv, 32'h0800_0000);
    chk("R12 irq still high", 32'(irqOut), 32'd1);

    // R10 core reset, non-key ignored
    expN = 0;
    pushWords(2);
    wrReg(8'h28, 32'h0000_0011);
    rdReg(8'h04, rv); chk("R10 non-key enable", rv, 32'h0800_0000);
    rdReg(8'h00, rv); chk("R10 non-key status", rv, 32'h0800_0000);
    rdReg(8'h0C, rv); chk("R10 non-key vacancy", rv, expVacancy(2));
    wrReg(8'h28, 32'h0000_00A5);
    rdReg(8'h00, rv); chk("R10 status cleared", rv, 32'd0);
    rdReg(8'h04, rv); chk("R10 enable cleared", rv, 32'd0);
    rdReg(8'h0C, rv); chk("R10 vacancy", rv, expVacancy(0));
    chk("R10 irq", 32'(irqOut), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule